// File: doc/BRIEF.md
# Stream Handshake and Ordering Monitor

This block is a passive, synthesizable observer for a buffered stream channel. It watches two sides of a block under test: the upstream side, where words enter, and the downstream side, where they leave. Each side is a valid/ready/data triple. The monitor only receives these signals and never drives any of them. It reports rule breaks through sticky error flags, which stay set until the next reset.

Two kinds of rule are checked on each side, and both compare this cycle's values with the values registered in the cycle before. The hold rule says a word that is offered but not yet accepted must not change. The ready rule says that a ready which is raised while nothing is offered must not be withdrawn. Ordering is checked with two probe values, `probe_a` and `probe_b`, which must stay constant between resets. Four sticky seen-flags record whether each probe has appeared on each side. The probe marked `probe_a` is taken to enter first, and a side on which `probe_b` appears before `probe_a` has been seen is flagged. This cannot catch every reordering, but any pair of probe values can be chosen, so sweeping the pair over many runs covers the ordering property without a reference queue.

Top module: `stream_order_monitor`

## Requirements
- R1: While `rst` is high at a rising edge, every error output and every seen-flag is cleared, so all error outputs read 0 in the following cycle.
- R2: If `up_valid` is 1 and `up_ready` is 0 in a non-reset cycle, and in the next non-reset cycle `up_valid` or `up_data` differs, then `err_up_hold` reads 1 from the cycle after that second cycle.
- R3: The same hold rule applies on the downstream side (`dn_valid`, `dn_ready`, `dn_data`) and sets `err_dn_hold`.
- R4: If ready is 1 and valid is 0 on a side in a non-reset cycle, and ready is 0 in the next non-reset cycle, then that side's ready error (`err_up_ready` or `err_dn_ready`) reads 1 from the cycle after.
- R5: No stability error is raised for the first cycle after reset is released, whatever the values were during the last reset cycle.
- R6: A probe counts as seen on a side only when that side's valid is 1 and its data equals the probe. If `probe_b` is seen upstream while `probe_a` has not yet been seen there, `err_in_order` reads 1 in the cycle after that word. A probe value presented with valid low is ignored.
- R7: The same ordering rule applies on the downstream side and sets `err_out_order`.
- R8: When `probe_a` equals `probe_b`, neither ordering error is ever raised.
- R9: Every error output is sticky until the next reset, and `err_any` is the OR of the six error outputs.
- R10: Traffic that obeys both stability rules and presents `probe_a` before `probe_b` on each side raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| probe_a | input | W | Probe value expected first |
| probe_b | input | W | Probe value expected second |
| up_valid | input | 1 | Upstream valid |
| up_data | input | W | Upstream data |
| up_ready | input | 1 | Upstream ready |
| dn_valid | input | 1 | Downstream valid |
| dn_data | input | W | Downstream data |
| dn_ready | input | 1 | Downstream ready |
| err_up_hold | output | 1 | Upstream offered word changed before acceptance |
| err_dn_hold | output | 1 | Downstream offered word changed before acceptance |
| err_up_ready | output | 1 | Upstream ready withdrawn while idle |
| err_dn_ready | output | 1 | Downstream ready withdrawn while idle |
| err_in_order | output | 1 | `probe_b` seen upstream before `probe_a` |
| err_out_order | output | 1 | `probe_b` seen downstream before `probe_a` |
| err_any | output | 1 | OR of all error outputs |

## Verification
If a previous-cycle register holds a stale value, a false or missing stability error shows up one cycle after the second cycle of the offending pair. This state is checked in every cycle against a bench model, under random compliant traffic that has rare injected violations. If a seen-flag is lost or set wrongly, a missed or spurious ordering error appears in the cycle right after the probe word. A flag that fails to stay sticky shows on `err_any` at the next clean cycle. The directed cases cover the cycle just after reset release, probes shown with valid low, and equal probes.

// File: rtl/stream_order_monitor.sv
module stream_order_monitor #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] probe_a,
  input  logic [W-1:0] probe_b,
  input  logic         up_valid,
  input  logic [W-1:0] up_data,
  input  logic         up_ready,
  input  logic         dn_valid,
  input  logic [W-1:0] dn_data,
  input  logic         dn_ready,
  output logic         err_up_hold,
  output logic         err_dn_hold,
  output logic         err_up_ready,
  output logic         err_dn_ready,
  output logic         err_in_order,
  output logic         err_out_order,
  output logic         err_any
);

  logic         live;
  logic         pv_u, pr_u, pv_d, pr_d;
  logic [W-1:0] pd_u, pd_d;
  logic [3:0]   seen;
  logic [3:0]   seen_nx;
  logic         hold_u, hold_d, rdy_u, rdy_d;
  logic         probes_differ;

  always_ff @(posedge clk) begin
    pv_u <= up_valid;
    pr_u <= up_ready;
    pd_u <= up_data;
    pv_d <= dn_valid;
    pr_d <= dn_ready;
    pd_d <= dn_data;
  end

  assign hold_u = live && pv_u && !pr_u && (up_valid != pv_u || up_data != pd_u);
  assign hold_d = live && pv_d && !pr_d && (dn_valid != pv_d || dn_data != pd_d);
  assign rdy_u  = live && pr_u && !pv_u && !up_ready;
  assign rdy_d  = live && pr_d && !pv_d && !dn_ready;

  assign probes_differ = (probe_a != probe_b);

  // bit 0: a upstream, 1: b upstream, 2: a downstream, 3: b downstream
  assign seen_nx = seen | {dn_valid && dn_data == probe_b,
                           dn_valid && dn_data == probe_a,
                           up_valid && up_data == probe_b,
                           up_valid && up_data == probe_a};

  always_ff @(posedge clk) begin
    if (rst) begin
      live          <= 1'b0;
      seen          <= '0;
      err_up_hold   <= 1'b0;
      err_dn_hold   <= 1'b0;
      err_up_ready  <= 1'b0;
      err_dn_ready  <= 1'b0;
      err_in_order  <= 1'b0;
      err_out_order <= 1'b0;
    end else begin
      live          <= 1'b1;
      seen          <= seen_nx;
      err_up_hold   <= err_up_hold  | hold_u;
      err_dn_hold   <= err_dn_hold  | hold_d;
      err_up_ready  <= err_up_ready | rdy_u;
      err_dn_ready  <= err_dn_ready | rdy_d;
      err_in_order  <= err_in_order  | (probes_differ && seen_nx[1] && !seen_nx[0]);
      err_out_order <= err_out_order | (probes_differ && seen_nx[3] && !seen_nx[2]);
    end
  end

  assign err_any = err_up_hold | err_dn_hold | err_up_ready | err_dn_ready |
                   err_in_order | err_out_order;

endmodule

// File: rtl/stream_order_monitor_sva.sv
module stream_order_monitor_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] probe_a,
  input logic [W-1:0] probe_b,
  input logic         up_valid,
  input logic [W-1:0] up_data,
  input logic         up_ready,
  input logic         dn_valid,
  input logic [W-1:0] dn_data,
  input logic         dn_ready,
  input logic         err_up_hold,
  input logic         err_dn_hold,
  input logic         err_up_ready,
  input logic         err_dn_ready,
  input logic         err_in_order,
  input logic         err_any
);

  logic warm = 1'b0;
  always_ff @(posedge clk) warm <= !rst;

  p_clear_r1: assert property (@(posedge clk) rst |=> !err_any);

  p_uphold_r2: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(up_valid && !up_ready) &&
     (up_valid != $past(up_valid) || up_data != $past(up_data))) |=> err_up_hold);

  p_dnhold_r3: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(dn_valid && !dn_ready) &&
     (dn_valid != $past(dn_valid) || dn_data != $past(dn_data))) |=> err_dn_hold);

  p_upready_r4: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(up_ready && !up_valid) && !up_ready) |=> err_up_ready);

  p_dnready_r4: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(dn_ready && !dn_valid) && !dn_ready) |=> err_dn_ready);

  p_equal_r8: assert property (@(posedge clk) disable iff (rst)
    (probe_a == probe_b && !err_in_order) |=> !err_in_order);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_any |=> err_any);

endmodule

bind stream_order_monitor stream_order_monitor_sva #(.W(W)) u_sva (
  .clk(clk), .rst(rst), .probe_a(probe_a), .probe_b(probe_b),
  .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
  .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready),
  .err_up_hold(err_up_hold), .err_dn_hold(err_dn_hold),
  .err_up_ready(err_up_ready), .err_dn_ready(err_dn_ready),
  .err_in_order(err_in_order), .err_any(err_any)
);

// File: tb/tb_stream_order_monitor.sv
module tb_stream_order_monitor;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] probe_a = 8'h11, probe_b = 8'h22;
  logic         up_valid = 0, up_ready = 0, dn_valid = 0, dn_ready = 0;
  logic [W-1:0] up_data = 0, dn_data = 0;
  logic err_up_hold, err_dn_hold, err_up_ready, err_dn_ready;
  logic err_in_order, err_out_order, err_any;

  always #10 clk = ~clk;

  stream_order_monitor #(.W(W)) dut (
    .clk(clk), .rst(rst), .probe_a(probe_a), .probe_b(probe_b),
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .dn_valid(dn_valid), .dn_data(dn_data), .dn_ready(dn_ready),
    .err_up_hold(err_up_hold), .err_dn_hold(err_dn_hold),
    .err_up_ready(err_up_ready), .err_dn_ready(err_dn_ready),
    .err_in_order(err_in_order), .err_out_order(err_out_order),
    .err_any(err_any)
  );

  int vectors = 0, bad = 0;

  // expected state: m_err bits 0 uphold,1 dnhold,2 upready,3 dnready,4 inorder,5 outorder
  logic         m_live = 0;
  logic [3:0]   m_seen = 0;
  logic [5:0]   m_err = 0;
  logic         pv_u = 0, pr_u = 0, pv_d = 0, pr_d = 0;
  logic [W-1:0] pd_u = 0, pd_d = 0;

  function automatic string tag_of(int b);
    case (b)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R4";
      4: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic model_edge();
    logic [3:0] ns;
    if (rst) begin
      m_live = 0; m_seen = 0; m_err = 0;
    end else begin
      if (m_live && pv_u && !pr_u && (up_valid !== pv_u || up_data !== pd_u)) m_err[0] = 1;
      if (m_live && pv_d && !pr_d && (dn_valid !== pv_d || dn_data !== pd_d)) m_err[1] = 1;
      if (m_live && pr_u && !pv_u && !up_ready) m_err[2] = 1;
      if (m_live && pr_d && !pv_d && !dn_ready) m_err[3] = 1;
      ns = m_seen;
      if (up_valid && up_data == probe_a) ns[0] = 1;
      if (up_valid && up_data == probe_b) ns[1] = 1;
      if (dn_valid && dn_data == probe_a) ns[2] = 1;
      if (dn_valid && dn_data == probe_b) ns[3] = 1;
      if (probe_a != probe_b && ns[1] && !ns[0]) m_err[4] = 1;
      if (probe_a != probe_b && ns[3] && !ns[2]) m_err[5] = 1;
      m_seen = ns;
      m_live = 1;
    end
    pv_u = up_valid; pr_u = up_ready; pd_u = up_data;
    pv_d = dn_valid; pr_d = dn_ready; pd_d = dn_data;
  endtask

  function automatic logic [5:0] got_errs();
    return {err_out_order, err_in_order, err_dn_ready, err_up_ready, err_dn_hold, err_up_hold};
  endfunction

  task automatic model_check();
    vectors++;
    if (got_errs() !== m_err || err_any !== (|m_err)) begin
      bad++;
      for (int b = 0; b < 6; b++)
        if (got_errs()[b] !== m_err[b])
          $display("FAIL %s model bit %0d: got %b exp %b", tag_of(b), b, got_errs()[b], m_err[b]);
      if (err_any !== (|m_err))
        $display("FAIL R9 err_any: got %b exp %b", err_any, |m_err);
    end
  endtask

  task automatic expect_errs(string tag, logic [5:0] exp);
    vectors++;
    if (got_errs() !== exp || err_any !== (|exp)) begin
      bad++;
      $display("FAIL %s: got %b/%b exp %b/%b", tag, got_errs(), err_any, exp, |exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    model_check();
  endtask

  task automatic drive(logic uv, logic [W-1:0] ud, logic ur, logic dv, logic [W-1:0] dd, logic dr);
    up_valid = uv; up_data = ud; up_ready = ur;
    dn_valid = dv; dn_data = dd; dn_ready = dr;
  endtask

  task automatic do_reset(logic [W-1:0] a, logic [W-1:0] b);
    rst = 1; probe_a = a; probe_b = b;
    drive(0, 0, 0, 0, 0, 0);
    cyc(); cyc();
    rst = 0;
  endtask

  logic done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(8'h11, 8'h22);
    cyc(); expect_errs("R1 after reset", 6'b0);

    // R5: offered word changes across the reset release
    rst = 1; drive(1, 8'h03, 0, 0, 0, 0); cyc();
    rst = 0; drive(1, 8'h04, 0, 0, 0, 0); cyc();
    expect_errs("R5 first cycle after release", 6'b0);
    cyc(); drive(1, 8'h04, 1, 0, 0, 0); cyc();
    drive(0, 0, 0, 0, 0, 0); cyc();
    expect_errs("R5 no later error", 6'b0);

    // R2 and R9
    drive(1, 8'h05, 0, 0, 0, 0); cyc();
    drive(1, 8'h06, 0, 0, 0, 0); cyc();
    expect_errs("R2 upstream data changed", 6'b000001);
    drive(1, 8'h06, 1, 0, 0, 0); cyc();
    drive(0, 0, 0, 0, 0, 0); cyc(); cyc();
    expect_errs("R9 sticky", 6'b000001);
    do_reset(8'h11, 8'h22); cyc();
    expect_errs("R1 clears sticky", 6'b0);

    // R3
    drive(0, 0, 0, 1, 8'h05, 0); cyc();
    drive(0, 0, 0, 0, 8'h05, 0); cyc();
    expect_errs("R3 downstream valid dropped", 6'b000010);
    do_reset(8'h11, 8'h22);

    // R4 both sides
    drive(0, 0, 1, 0, 0, 0); cyc();
    drive(0, 0, 0, 0, 0, 0); cyc();
    expect_errs("R4 upstream ready withdrawn", 6'b000100);
    do_reset(8'h11, 8'h22);
    drive(0, 0, 0, 0, 0, 1); cyc();
    drive(0, 0, 0, 0, 0, 0); cyc();
    expect_errs("R4 downstream ready withdrawn", 6'b001000);
    do_reset(8'h11, 8'h22);

    // R6
    drive(1, 8'h22, 1, 0, 0, 0); cyc();
    expect_errs("R6 b before a upstream", 6'b010000);
    do_reset(8'h11, 8'h22);

    // R6 valid-low ignored, then R10 ordered traffic
    drive(0, 8'h22, 0, 0, 8'h22, 0); cyc();
    expect_errs("R6 probe with valid low ignored", 6'b0);
    drive(1, 8'h11, 1, 0, 0, 0); cyc();
    drive(1, 8'h22, 1, 1, 8'h11, 1); cyc();
    drive(0, 0, 1, 1, 8'h22, 1); cyc();
    drive(0, 0, 1, 0, 0, 1); cyc();
    expect_errs("R10 ordered compliant traffic", 6'b0);
    do_reset(8'h11, 8'h22);

    // R7
    drive(0, 0, 0, 1, 8'h22, 1); cyc();
    expect_errs("R7 b before a downstream", 6'b100000);

    // R8
    do_reset(8'h33, 8'h33);
    drive(1, 8'h33, 1, 1, 8'h33, 1); cyc();
    drive(0, 0, 0, 0, 0, 0); cyc();
    expect_errs("R8 equal probes", 6'b0);

    // random phase, checked against the model each cycle
    for (int blk = 0; blk < 12; blk++) begin
      do_reset(W'($urandom_range(0, 7)), W'($urandom_range(0, 7)));
      for (int i = 0; i < 300; i++) begin
        logic uv, ur, dv, dr;
        logic [W-1:0] ud, dd;
        if (pv_u && !pr_u && $urandom_range(0, 99) >= 2) begin uv = pv_u; ud = pd_u; end
        else begin uv = 1'($urandom_range(0, 1)); ud = W'($urandom_range(0, 7)); end
        if (pr_u && !pv_u && $urandom_range(0, 99) >= 2) ur = 1;
        else ur = 1'($urandom_range(0, 1));
        if (pv_d && !pr_d && $urandom_range(0, 99) >= 2) begin dv = pv_d; dd = pd_d; end
        else begin dv = 1'($urandom_range(0, 1)); dd = W'($urandom_range(0, 7)); end
        if (pr_d && !pv_d && $urandom_range(0, 99) >= 2) dr = 1;
        else dr = 1'($urandom_range(0, 1));
        drive(uv, ud, ur, dv, dd, dr);
        cyc();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule